// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus slave that watches an oversampled SCL/SDA pair with the system clock. It gives a bus controller access to two 8-bit synthesizer setting registers, a low byte and a high byte, and to one command port that can only be written. The slave never drives SCL. It pulls SDA low through an open-drain enable, which is high while the line must be held low.

In a write transfer the controller sends the device address and then any number of pairs. Each pair is a register selector byte followed by a data byte. A read transfer has no pointer phase: once the address is acknowledged, the slave sends the low register and then the high register. A byte written to the command port appears on a data output, with a strobe that is high for one clock cycle. The chip logic around the block uses the two register outputs directly.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The 7-bit device address is binary 10110 in bits 6..2, with strap[1] in bit 1 and strap[0] in bit 0. The eighth bit of the address byte is 0 for a write and 1 for a read.
- R2: In a write, selector 0x00 stores the next data byte in reg_lo, and selector 0x01 stores it in reg_hi.
- R3: Selector/data pairs may repeat inside one transfer, in any count and any order. Each pair takes effect, and the last write to a register wins.
- R4: In a write transfer the slave pulls SDA low in the acknowledge slot of every byte, from the matched address byte onwards.
- R5: In a read transfer the slave acknowledges the address. It then sends reg_lo and then reg_hi, most significant bit first, with no selector phase.
- R6: Writing selector 0xF0 raises cmd_stb for exactly one clock cycle, with the data byte on cmd_data in that cycle. This write leaves reg_lo and reg_hi unchanged, and a read still returns the low and high registers.
- R7: A selector other than 0x00, 0x01 or 0xF0 is still acknowledged. Its data byte is also acknowledged and then dropped: no register changes and no strobe is raised.
- R8: If the address does not match, the slave gives no acknowledge and keeps SDA released until the next START or STOP. Bytes sent in that time have no effect.
- R9: During a read, once the controller answers a byte with NACK, the slave releases SDA before the next SCL high phase and drives nothing until a new START.
- R10: Reset sets reg_lo to LO_INIT and reg_hi to HI_INIT, releases SDA and clears cmd_stb.
- R11: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP ends a transfer and discards any half-finished pair. A repeated START begins a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 2 | Board straps, address bits 1..0 |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| reg_lo | output | 8 | Low synthesizer register |
| reg_hi | output | 8 | High synthesizer register |
| cmd_stb | output | 1 | One-cycle pulse on a command write |
| cmd_data | output | 8 | Byte last written to the command port |

## Verification
The assertions assume a well-formed bus:
- SDA changes only while SCL is low, except at START and STOP.
- The controller never signals START or STOP while the slave is pulling SDA low.
- Each SCL phase lasts longer than the synchronizer and edge-detect latency, so the slave's drive changes settle inside the low phase.

The stimulus keeps to these rules. Every SCL quarter period is eight system clocks, SDA is changed only in the first quarter of a low phase, and the controller releases SDA in every slot where the slave may drive. Random write transfers mix the valid selectors, unused selectors and the command port in random order and count. Directed transfers cover the edge cases: mismatched addresses, NACK mid-read, and a STOP or repeated START partway through a transfer.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [4:0] DEV_ID = 5'b10110;

    localparam logic [BYTE_W-1:0] SEL_LO  = 8'h00;
    localparam logic [BYTE_W-1:0] SEL_HI  = 8'h01;
    localparam logic [BYTE_W-1:0] SEL_CMD = 8'hF0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK
    } state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_SEL,
        K_DATA
    } kind_e;

    typedef enum logic [1:0] {
        T_NONE,
        T_LO,
        T_HI,
        T_CMD
    } target_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } line_ev_t;

    function automatic target_e decode_sel(input logic [BYTE_W-1:0] sel);
        target_e t;
        case (sel)
            SEL_LO:  t = T_LO;
            SEL_HI:  t = T_HI;
            SEL_CMD: t = T_CMD;
            default: t = T_NONE;
        endcase
        return t;
    endfunction

    function automatic logic dev_match(input logic [6:0] addr,
                                       input logic [1:0] strap);
        return addr == {DEV_ID, strap};
    endfunction

endpackage

// File: rtl/cfgslv_sync.sv
module cfgslv_sync
    import cfgslv_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    localparam int TOP = STAGES - 1;

    logic [TOP:0] scl_p;
    logic [TOP:0] sda_p;
    logic         scl_q;
    logic         sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= scl_in;
                    sda_p <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= {scl_p[TOP-1:0], scl_in};
                    sda_p <= {sda_p[TOP-1:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_p[TOP];
            sda_q <= sda_p[TOP];
        end
    end

    always_comb begin
        ev.scl   = scl_p[TOP];
        ev.sda   = sda_p[TOP];
        ev.start = scl_p[TOP] & scl_q & sda_q & ~sda_p[TOP];
        ev.stop  = scl_p[TOP] & scl_q & ~sda_q & sda_p[TOP];
        ev.rise  = scl_p[TOP] & ~scl_q;
        ev.fall  = ~scl_p[TOP] & scl_q;
    end

endmodule

// File: rtl/cfgslv_fsm.sv
module cfgslv_fsm
    import cfgslv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] rd_lo,
    input  logic [BYTE_W-1:0] rd_hi,
    output logic              sda_oe,
    output logic              wr_en,
    output target_e           wr_tgt,
    output logic [BYTE_W-1:0] wr_data
);

    state_e            st;
    kind_e             kind;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              is_rd;
    target_e           sel_tgt;
    logic              next_hi;
    logic              nack;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [BYTE_W-1:0] tx_next;
    assign tx_next = next_hi ? rd_hi : rd_lo;

    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (rst) begin
            st      <= S_IDLE;
            kind    <= K_DEV;
            cnt     <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            is_rd   <= 1'b0;
            sel_tgt <= T_NONE;
            next_hi <= 1'b0;
            nack    <= 1'b0;
            sda_oe  <= 1'b0;
            wr_tgt  <= T_NONE;
            wr_data <= '0;
        end else if (ev.start) begin
            st     <= S_RX;
            kind   <= K_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            st     <= S_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    sda_oe <= 1'b0;
                end
                S_RX: begin
                    if (ev.rise && cnt != FULL) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], ev.sda};
                        cnt   <= cnt + 1'b1;
                    end else if (ev.fall && cnt == FULL) begin
                        cnt <= '0;
                        case (kind)
                            K_DEV: begin
                                if (dev_match(rx_sh[BYTE_W-1:1], strap)) begin
                                    is_rd  <= rx_sh[0];
                                    sda_oe <= 1'b1;
                                    st     <= S_ACK;
                                end else begin
                                    st <= S_IDLE;
                                end
                            end
                            K_SEL: begin
                                sel_tgt <= decode_sel(rx_sh);
                                sda_oe  <= 1'b1;
                                st      <= S_ACK;
                            end
                            default: begin
                                wr_en   <= 1'b1;
                                wr_tgt  <= sel_tgt;
                                wr_data <= rx_sh;
                                sda_oe  <= 1'b1;
                                st      <= S_ACK;
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (ev.fall) begin
                        if (kind == K_DEV && is_rd) begin
                            tx_sh   <= {rd_lo[BYTE_W-2:0], 1'b0};
                            sda_oe  <= ~rd_lo[BYTE_W-1];
                            cnt     <= CNT_W'(1);
                            next_hi <= 1'b1;
                            st      <= S_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            kind   <= (kind == K_SEL) ? K_DATA : K_SEL;
                            st     <= S_RX;
                        end
                    end
                end
                S_TX: begin
                    if (ev.fall) begin
                        if (cnt == FULL) begin
                            sda_oe <= 1'b0;
                            st     <= S_MACK;
                        end else begin
                            sda_oe <= ~tx_sh[BYTE_W-1];
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            cnt    <= cnt + 1'b1;
                        end
                    end
                end
                S_MACK: begin
                    if (ev.rise) begin
                        nack <= ev.sda;
                    end else if (ev.fall) begin
                        if (nack) begin
                            sda_oe <= 1'b0;
                            st     <= S_IDLE;
                        end else begin
                            tx_sh   <= {tx_next[BYTE_W-2:0], 1'b0};
                            sda_oe  <= ~tx_next[BYTE_W-1];
                            cnt     <= CNT_W'(1);
                            next_hi <= ~next_hi;
                            st      <= S_TX;
                        end
                    end
                end
                default: begin
                    st     <= S_IDLE;
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/cfgslv_regs.sv
module cfgslv_regs
    import cfgslv_pkg::*;
#(
    parameter logic [7:0] LO_INIT = 8'h00,
    parameter logic [7:0] HI_INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  target_e           wr_tgt,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] reg_lo,
    output logic [BYTE_W-1:0] reg_hi,
    output logic              cmd_stb,
    output logic [BYTE_W-1:0] cmd_data
);

    always_ff @(posedge clk) begin
        cmd_stb <= 1'b0;
        if (rst) begin
            reg_lo   <= LO_INIT;
            reg_hi   <= HI_INIT;
            cmd_data <= '0;
        end else if (wr_en) begin
            case (wr_tgt)
                T_LO: reg_lo <= wr_data;
                T_HI: reg_hi <= wr_data;
                T_CMD: begin
                    cmd_stb  <= 1'b1;
                    cmd_data <= wr_data;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import cfgslv_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] LO_INIT     = 8'h00,
    parameter logic [7:0] HI_INIT     = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] strap,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic [7:0] reg_lo,
    output logic [7:0] reg_hi,
    output logic       cmd_stb,
    output logic [7:0] cmd_data
);

    line_ev_t          ev;
    logic              ln_start;
    logic              ln_stop;
    logic              ln_scl;
    logic              wr_en;
    target_e           wr_tgt;
    logic [BYTE_W-1:0] wr_data;

    cfgslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    assign ln_start = ev.start;
    assign ln_stop  = ev.stop;
    assign ln_scl   = ev.scl;

    cfgslv_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .strap   (strap),
        .rd_lo   (reg_lo),
        .rd_hi   (reg_hi),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_tgt  (wr_tgt),
        .wr_data (wr_data)
    );

    cfgslv_regs #(.LO_INIT(LO_INIT), .HI_INIT(HI_INIT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_tgt   (wr_tgt),
        .wr_data  (wr_data),
        .reg_lo   (reg_lo),
        .reg_hi   (reg_hi),
        .cmd_stb  (cmd_stb),
        .cmd_data (cmd_data)
    );

endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk
    import cfgslv_pkg::*;
#(
    parameter logic [7:0] LO_INIT = 8'h00,
    parameter logic [7:0] HI_INIT = 8'h00
) (
    input logic       clk,
    input logic       rst,
    input logic       sda_oe,
    input logic       cmd_stb,
    input logic [7:0] reg_lo,
    input logic [7:0] reg_hi,
    input logic       wr_en,
    input target_e    wr_tgt,
    input logic       ln_start,
    input logic       ln_stop,
    input logic       ln_scl
);

    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (!sda_oe && !cmd_stb && reg_lo == LO_INIT && reg_hi == HI_INIT));

    p_lo_source_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_lo) |-> ($past(wr_en) && $past(wr_tgt) == T_LO));

    p_hi_source_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_hi) |-> ($past(wr_en) && $past(wr_tgt) == T_HI));

    p_cmd_single_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |=> !cmd_stb);

    p_cmd_source_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> ($past(wr_en) && $past(wr_tgt) == T_CMD));

    p_discard_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_tgt == T_NONE) |=> ($stable(reg_lo) && $stable(reg_hi) && !cmd_stb));

    p_drive_low_phase_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(ln_scl));

    p_stop_release_r11: assert property (@(posedge clk) disable iff (rst)
        ln_stop |=> !sda_oe);

    p_start_release_r11: assert property (@(posedge clk) disable iff (rst)
        ln_start |=> !sda_oe);

endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(
    .LO_INIT(LO_INIT),
    .HI_INIT(HI_INIT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe),
    .cmd_stb  (cmd_stb),
    .reg_lo   (reg_lo),
    .reg_hi   (reg_hi),
    .wr_en    (wr_en),
    .wr_tgt   (wr_tgt),
    .ln_start (ln_start),
    .ln_stop  (ln_stop),
    .ln_scl   (ln_scl)
);

// File: tb/i2c_cfg_slave_test.sv
module i2c_cfg_slave_test;

    localparam logic [7:0] LO_INIT = 8'h2D;
    localparam logic [7:0] HI_INIT = 8'hC1;
    localparam int         Q       = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic [7:0] reg_lo;
    logic [7:0] reg_hi;
    logic       cmd_stb;
    logic [7:0] cmd_data;
    logic       sda_line;

    assign sda_line = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    i2c_cfg_slave #(.LO_INIT(LO_INIT), .HI_INIT(HI_INIT)) uut (
        .clk      (clk),
        .rst      (rst),
        .strap    (strap),
        .scl_in   (m_scl),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .reg_lo   (reg_lo),
        .reg_hi   (reg_hi),
        .cmd_stb  (cmd_stb),
        .cmd_data (cmd_data)
    );

    int checks = 0;
    int fails  = 0;
    int stb_cnt = 0;
    logic [7:0] stb_last = 8'h00;
    logic [7:0] exp_lo = LO_INIT;
    logic [7:0] exp_hi = HI_INIT;
    int exp_stb = 0;
    logic [7:0] exp_cmd = 8'h00;
    logic done = 1'b0;

    always @(negedge clk) begin
        if (!rst && cmd_stb) begin
            stb_cnt  <= stb_cnt + 1;
            stb_last <= cmd_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait();
        qwait();
    endtask

    task automatic wbit(input logic b);
        m_sda = b; qwait();
        m_scl = 1'b1; qwait(); qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        b = sda_line; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic wbyte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        acked = ~a;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic nak);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(nak);
    endtask

    function automatic logic [7:0] dev_byte(input logic [1:0] s, input logic rd);
        return {5'b10110, s, rd};
    endfunction

    function automatic void model_write(input logic [7:0] sel, input logic [7:0] d);
        if (sel == 8'h00) exp_lo = d;
        else if (sel == 8'h01) exp_hi = d;
        else if (sel == 8'hF0) begin
            exp_stb++;
            exp_cmd = d;
        end
    endfunction

    task automatic write_pair(input string req, input logic [7:0] sel, input logic [7:0] d);
        logic ak;
        wbyte(sel, ak);
        check({req, " selector ack"}, ak, 1'b1);
        wbyte(d, ak);
        check({req, " data ack"}, ak, 1'b1);
        model_write(sel, d);
    endtask

    task automatic read_back(input string req);
        logic ak;
        logic [7:0] a;
        logic [7:0] b;
        bus_start();
        wbyte(dev_byte(strap, 1'b1), ak);
        check({req, " read address ack"}, ak, 1'b1);
        rbyte(a, 1'b0);
        rbyte(b, 1'b1);
        bus_stop();
        check({req, " read low byte"}, a, exp_lo);
        check({req, " read high byte"}, b, exp_hi);
    endtask

    task automatic check_ports(input string req);
        check({req, " reg_lo"}, reg_lo, exp_lo);
        check({req, " reg_hi"}, reg_hi, exp_hi);
        check({req, " strobe count"}, stb_cnt, exp_stb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic ak;
        logic [7:0] v;
        void'($urandom(32'd5150));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: state after reset
        check("R10 reg_lo", reg_lo, LO_INIT);
        check("R10 reg_hi", reg_hi, HI_INIT);
        check("R10 sda_oe", sda_oe, 1'b0);
        check("R10 cmd_stb", cmd_stb, 1'b0);

        // R1 R2 R4: basic write of both registers
        bus_start();
        wbyte(dev_byte(strap, 1'b0), ak);
        check("R1 R4 write address ack", ak, 1'b1);
        write_pair("R2 R4", 8'h00, 8'hA5);
        write_pair("R2 R4", 8'h01, 8'h3C);
        bus_stop();
        check_ports("R2");

        // R5: read returns low then high
        read_back("R5");

        // R3: reversed order and repeated register within one transfer
        bus_start();
        wbyte(dev_byte(strap, 1'b0), ak);
        check("R3 address ack", ak, 1'b1);
        write_pair("R3", 8'h01, 8'h81);
        write_pair("R3", 8'h00, 8'h18);
        write_pair("R3", 8'h01, 8'h7E);
        bus_stop();
        check_ports("R3");

        // R6: command write pulses once, registers untouched, not readable
        bus_start();
        wbyte(dev_byte(strap, 1'b0), ak);
        write_pair("R6", 8'hF0, 8'h5A);
        bus_stop();
        check_ports("R6");
        check("R6 cmd_data", stb_last, 8'h5A);
        read_back("R6");

        // R7: unused selectors are acked and ignored
        bus_start();
        wbyte(dev_byte(strap, 1'b0), ak);
        write_pair("R7", 8'h02, 8'hFF);
        write_pair("R7", 8'h7F, 8'h00);
        write_pair("R7", 8'hF1, 8'h11);
        bus_stop();
        check_ports("R7");

        // R8: wrong strap bits and wrong fixed bits
        bus_start();
        wbyte(dev_byte(2'b01, 1'b0), ak);
        check("R8 strap mismatch nack", ak, 1'b0);
        wbyte(8'h00, ak);
        check("R8 no ack after mismatch", ak, 1'b0);
        wbyte(8'h99, ak);
        check("R8 released", ak, 1'b0);
        bus_stop();
        bus_start();
        wbyte(8'b1011_1100, ak);
        check("R8 fixed bits mismatch nack", ak, 1'b0);
        wbyte(8'h01, ak);
        wbyte(8'h44, ak);
        bus_stop();
        check_ports("R8");

        // R1: a new strap value moves the address
        strap = 2'b01;
        bus_start();
        wbyte(dev_byte(2'b10, 1'b0), ak);
        check("R1 old strap rejected", ak, 1'b0);
        bus_stop();
        bus_start();
        wbyte(dev_byte(2'b01, 1'b0), ak);
        check("R1 new strap accepted", ak, 1'b1);
        write_pair("R1", 8'h00, 8'h66);
        bus_stop();
        check_ports("R1");

        // R9: after a NACK the slave stays off the bus
        bus_start();
        wbyte(dev_byte(strap, 1'b1), ak);
        check("R9 address ack", ak, 1'b1);
        rbyte(v, 1'b1);
        check("R9 first byte", v, exp_lo);
        rbyte(v, 1'b1);
        check("R9 released after nack", v, 8'hFF);
        bus_stop();

        // R11: STOP discards half a pair
        bus_start();
        wbyte(dev_byte(strap, 1'b0), ak);
        wbyte(8'h00, ak);
        bus_stop();
        bus_start();
        wbyte(dev_byte(strap, 1'b0), ak);
        write_pair("R11", 8'h01, 8'h77);
        bus_stop();
        check_ports("R11 stop mid-pair");

        // R11: repeated START switches to a read
        bus_start();
        wbyte(dev_byte(strap, 1'b0), ak);
        write_pair("R11", 8'h00, 8'hE4);
        bus_rstart();
        wbyte(dev_byte(strap, 1'b1), ak);
        check("R11 repeated start ack", ak, 1'b1);
        rbyte(v, 1'b0);
        check("R11 read low after restart", v, exp_lo);
        rbyte(v, 1'b1);
        check("R11 read high after restart", v, exp_hi);
        bus_stop();

        // R3 R6 R7: random write transfers
        for (int t = 0; t < 20; t++) begin
            int npairs;
            npairs = 1 + int'($urandom % 4);
            bus_start();
            wbyte(dev_byte(strap, 1'b0), ak);
            check("R3 random address ack", ak, 1'b1);
            for (int p = 0; p < npairs; p++) begin
                logic [7:0] sel;
                logic [7:0] d;
                d = 8'($urandom);
                case ($urandom % 4)
                    0: sel = 8'h00;
                    1: sel = 8'h01;
                    2: sel = 8'hF0;
                    default: begin
                        sel = 8'($urandom);
                        if (sel == 8'h00 || sel == 8'h01 || sel == 8'hF0) sel = 8'h42;
                    end
                endcase
                write_pair("R3 R7 random", sel, d);
            end
            bus_stop();
            check_ports("R3 random");
            if (exp_stb > 0) check("R6 random cmd_data", stb_last, exp_cmd);
            if (t % 4 == 3) read_back("R5 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule